// File: doc/BRIEF.md
# Eight-Bit Arithmetic Logic Unit with Status Flags

This block is a purely combinational arithmetic logic unit. It takes two operands of `WIDTH` bits (eight by default), and a three-bit operation code selects one of eight functions. It returns a result word and three status flags: a carry/compare flag, a signed-overflow flag and a zero flag. It holds no state, so a new result appears in the same cycle that the inputs change. A surrounding datapath registers it wherever its timing needs.

The unit is made of separate submodules wired together structurally. A ripple-carry adder handles addition, subtraction and the magnitude compare. A restoring-division array produces the remainder. A bitwise unit builds the AND, OR, nibble-concatenation and equality terms. An output selector picks the result for the operation code and forms the flags. The compare operations report only through a flag: less-than reports on the carry output and equality reports on the zero output, and for both of them the result word is held at zero.

Top module: `alu8_flags`

## Requirements
- R1: With op code 000, the result is all zeros and the carry output is 1 exactly when X is less than Y, both taken as unsigned.
- R2: With op code 001, the result is the low WIDTH bits of X + Y and the carry output is the carry out of the top bit.
- R3: With op code 010, the result is the low WIDTH bits of X − Y and the carry output is 1 exactly when no borrow occurs (X ≥ Y unsigned).
- R4: With op codes 001 and 010, the overflow flag is 1 exactly when the two's-complement result does not fit. For add, this means both operands have the same sign and the result's sign differs. For subtract, it means the operands' signs differ and the result's sign differs from X.
- R5: With op code 011 and a nonzero Y, the result is X modulo Y (unsigned).
- R6: With op code 011 and Y equal to zero, the result is X itself.
- R7: With op code 100 the result is the bitwise AND of X and Y. With op code 101 it is the bitwise OR.
- R8: With op code 110, the result's upper half is the lower half of X and the result's lower half is the lower half of Y.
- R9: With op code 111, the result is all zeros and the zero flag is 1 exactly when X equals Y.
- R10: For every op code except 111, the zero flag is 1 exactly when the result is all zeros.
- R11: The carry output is 0 for op codes 011 through 111. The overflow flag is 0 for every op code other than 001 and 010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code selecting one of eight functions |
| x_i | input | WIDTH | First operand |
| y_i | input | WIDTH | Second operand |
| z_o | output | WIDTH | Result word |
| cout_o | output | 1 | Carry out, no-borrow flag, or less-than result, depending on op code |
| ov_o | output | 1 | Signed overflow for add and subtract |
| zero_o | output | 1 | Result-is-zero flag, or operands-equal flag for op code 111 |

## Verification
The bench builds the unit with its default `WIDTH` of 8, so the nibble split in concatenation falls at bit 4. At this width the sign boundary between 0x7F and 0x80 is reached by both the add and subtract overflow cases. Directed operands cover that boundary, all-ones and all-zero words, and a zero divisor. A long pseudo-random sweep then runs every op code. The eight-bit width keeps the carry-out and borrow conditions within reach of ordinary operand pairs, and lets the remainder array be checked against unsigned modulo on divisors of every magnitude.

// File: rtl/alu8_pkg.sv
// Package: shared operation-code type for the eight-function ALU.
// Assumes: the code is three bits wide and every value is a legal operation.
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_LT  = 3'b000,
        OP_ADD = 3'b001,
        OP_SUB = 3'b010,
        OP_REM = 3'b011,
        OP_AND = 3'b100,
        OP_OR  = 3'b101,
        OP_CAT = 3'b110,
        OP_EQ  = 3'b111
    } alu_op_e;

endpackage

// File: rtl/alu8_addsub.sv
// Module: ripple-carry adder/subtractor.
// Computes a + b, or a + ~b + 1 when sub_i is set. Reports the final carry
// and a signed overflow taken from the carries into and out of the top bit.
// Assumes: WIDTH >= 2.
module alu8_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] b_eff;

    // Invert the second operand when subtracting; the carry-in supplies the +1.
    assign b_eff    = b_i ^ {WIDTH{sub_i}};
    assign carry[0] = sub_i;

    // One full-adder cell per bit, chained through the carry vector.
    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        assign sum_o[i]   = a_i[i] ^ b_eff[i] ^ carry[i];
        assign carry[i+1] = (a_i[i] & b_eff[i]) | (carry[i] & (a_i[i] ^ b_eff[i]));
    end

    assign cout_o = carry[WIDTH];
    assign ovf_o  = carry[WIDTH] ^ carry[WIDTH-1];

    // Check the bit-level chain against a word-level sum.
    always_comb begin
        AST_ADD_SUM: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_eff} + (WIDTH+1)'(sub_i))) // R2
            else $error("adder chain disagrees with word sum");
    end

endmodule

// File: rtl/alu8_rem.sv
// Module: restoring-division array that returns the unsigned remainder a mod b.
// There is one compare-and-subtract stage per dividend bit, working from the MSB down.
// Assumes: a zero divisor makes every stage subtract zero, so the result is a.
module alu8_rem #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] rem_o
);

    logic [WIDTH-1:0] part [0:WIDTH];

    assign part[0] = '0;

    // Each stage shifts in the next dividend bit and subtracts b if it fits.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic [WIDTH:0] shifted;
        logic [WIDTH:0] diff;
        logic           fits;
        assign shifted    = {part[i], a_i[WIDTH-1-i]};
        assign diff       = shifted - {1'b0, b_i};
        assign fits       = (shifted >= {1'b0, b_i});
        assign part[i+1]  = fits ? WIDTH'(diff) : WIDTH'(shifted);
    end

    assign rem_o = part[WIDTH];

    // Bound the remainder and pin down the zero-divisor result.
    always_comb begin
        if (b_i != '0) begin
            AST_REM_BOUND: assert (rem_o < b_i) // R5
                else $error("remainder not below divisor");
        end else begin
            AST_REM_DIVZERO: assert (rem_o == a_i) // R6
                else $error("zero divisor did not return dividend");
        end
    end

endmodule

// File: rtl/alu8_bitwise.sv
// Module: the bitwise and compare terms, meaning AND, OR, nibble concatenation
// and operand equality.
// Assumes: WIDTH is even, so that the concatenation splits into two halves.
module alu8_bitwise #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] cat_o,
    output logic             eq_o
);

    localparam int HALF = WIDTH / 2;

    // Per-bit logic terms.
    assign and_o = a_i & b_i;
    assign or_o  = a_i | b_i;

    // The low half of a goes to the upper half of the result; the low half of b stays low.
    assign cat_o = {a_i[HALF-1:0], b_i[HALF-1:0]};

    // Equality: no bit position differs.
    assign eq_o  = ~|(a_i ^ b_i);

endmodule

// File: rtl/alu8_outsel.sv
// Module: output selector and flag builder.
// Picks the result word for the operation code and forms the carry, overflow
// and zero flags.
// Assumes: the adder ran in subtract mode for the compare and subtract codes.
module alu8_outsel
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] sum_i,
    input  logic             carry_i,
    input  logic             ovf_i,
    input  logic [WIDTH-1:0] rem_i,
    input  logic [WIDTH-1:0] and_i,
    input  logic [WIDTH-1:0] or_i,
    input  logic [WIDTH-1:0] cat_i,
    input  logic             eq_i,
    output logic [WIDTH-1:0] z_o,
    output logic             cout_o,
    output logic             ov_o,
    output logic             zero_o
);

    // Select the result word and the carry/overflow flags for each code.
    always_comb begin
        z_o    = '0;
        cout_o = 1'b0;
        ov_o   = 1'b0;
        unique case (op_i)
            OP_LT:  cout_o = ~carry_i;
            OP_ADD: begin z_o = sum_i; cout_o = carry_i; ov_o = ovf_i; end
            OP_SUB: begin z_o = sum_i; cout_o = carry_i; ov_o = ovf_i; end
            OP_REM: z_o = rem_i;
            OP_AND: z_o = and_i;
            OP_OR:  z_o = or_i;
            OP_CAT: z_o = cat_i;
            OP_EQ:  z_o = '0;
            default: z_o = '0;
        endcase
    end

    // The zero flag reports equality for the equality code and a zero result otherwise.
    always_comb begin
        zero_o = (op_i == OP_EQ) ? eq_i : ~|z_o;
    end

endmodule

// File: rtl/alu8_flags.sv
// Module: top level of the combinational ALU.
// Wires the adder, remainder array, bitwise unit and output selector together.
// Assumes: no clock or reset; the outputs settle from the inputs alone.
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [2:0]       op_i,
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    output logic [WIDTH-1:0] z_o,
    output logic             cout_o,
    output logic             ov_o,
    output logic             zero_o
);

    localparam int HALF = WIDTH / 2;

    alu_op_e          op;
    logic             sub_mode;
    logic [WIDTH-1:0] sum;
    logic             carry;
    logic             ovf;
    logic [WIDTH-1:0] rem;
    logic [WIDTH-1:0] and_v;
    logic [WIDTH-1:0] or_v;
    logic [WIDTH-1:0] cat_v;
    logic             eq;

    // Decode the code and put the adder in subtract mode for the compare and subtract codes.
    always_comb begin
        op       = alu_op_e'(op_i);
        sub_mode = (op == OP_SUB) || (op == OP_LT);
    end

    alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i(x_i), .b_i(y_i), .sub_i(sub_mode),
        .sum_o(sum), .cout_o(carry), .ovf_o(ovf)
    );

    alu8_rem #(.WIDTH(WIDTH)) u_rem (
        .a_i(x_i), .b_i(y_i), .rem_o(rem)
    );

    alu8_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a_i(x_i), .b_i(y_i),
        .and_o(and_v), .or_o(or_v), .cat_o(cat_v), .eq_o(eq)
    );

    alu8_outsel #(.WIDTH(WIDTH)) u_outsel (
        .op_i(op), .sum_i(sum), .carry_i(carry), .ovf_i(ovf),
        .rem_i(rem), .and_i(and_v), .or_i(or_v), .cat_i(cat_v), .eq_i(eq),
        .z_o(z_o), .cout_o(cout_o), .ov_o(ov_o), .zero_o(zero_o)
    );

    // Cross-check the compare and quiet-flag behaviour at the ports.
    always_comb begin
        if (op == OP_LT) begin
            AST_LT_FLAG: assert (cout_o == (x_i < y_i) && z_o == '0) // R1
                else $error("less-than flag wrong");
        end
        if (op == OP_EQ) begin
            AST_EQ_FLAG: assert (zero_o == (x_i == y_i) && z_o == '0) // R9
                else $error("equality flag wrong");
        end
        if (op == OP_CAT) begin
            AST_CAT_ORDER: assert (z_o[WIDTH-1:HALF] == x_i[HALF-1:0] && z_o[HALF-1:0] == y_i[HALF-1:0]) // R8
                else $error("concatenation order wrong");
        end
        if (op != OP_ADD && op != OP_SUB) begin
            AST_OV_QUIET: assert (!ov_o) // R11
                else $error("overflow set outside add/sub");
        end
    end

endmodule

// File: tb/alu8_flags_test.sv
module alu8_flags_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int H = W / 2;

    typedef struct {
        logic [2:0]   op;
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic [W-1:0] z;
        logic         c;
        logic         v;
        logic         zf;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op = '0;
    logic [W-1:0] x = '0;
    logic [W-1:0] y = '0;
    logic [W-1:0] z;
    logic         cout, ov, zero;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];
    exp_t cur;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_flags #(.WIDTH(W)) uut (
        .op_i(op), .x_i(x), .y_i(y),
        .z_o(z), .cout_o(cout), .ov_o(ov), .zero_o(zero)
    );

    // Reference model built from the requirements.
    function automatic exp_t model(input logic [2:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
        exp_t e;
        logic [W:0] s;
        e.op = o; e.x = a; e.y = b; e.z = '0; e.c = 1'b0; e.v = 1'b0;
        case (o)
            3'b000: e.c = (a < b);
            3'b001: begin s = {1'b0, a} + {1'b0, b}; e.z = s[W-1:0]; e.c = s[W];
                          e.v = (a[W-1] == b[W-1]) && (e.z[W-1] != a[W-1]); end
            3'b010: begin e.z = a - b; e.c = (a >= b);
                          e.v = (a[W-1] != b[W-1]) && (e.z[W-1] != a[W-1]); end
            3'b011: e.z = (b == 0) ? a : (a % b);
            3'b100: e.z = a & b;
            3'b101: e.z = a | b;
            3'b110: e.z = {a[H-1:0], b[H-1:0]};
            default: e.z = '0;
        endcase
        e.zf = (o == 3'b111) ? (a == b) : (e.z == 0);
        return e;
    endfunction

    task automatic check(input logic ok, input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s op=%0d x=%h y=%h actual=%h expected=%h", tag, what, cur.op, cur.x, cur.y, act, expv);
        end
    endtask

    // Driver: apply one operation and push its expected outputs.
    task automatic drive(input logic [2:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
        @(posedge clk);
        #1;
        op = o; x = a; y = b;
        q.push_back(model(o, a, b));
    endtask

    // Monitor: at each falling edge, pop one expected item and compare all outputs.
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            string zt, ct, vt, ft;
            cur = q.pop_front();
            case (cur.op)
                3'b000: zt = "R1";
                3'b001: zt = "R2";
                3'b010: zt = "R3";
                3'b011: zt = (cur.y == 0) ? "R6" : "R5";
                3'b100, 3'b101: zt = "R7";
                3'b110: zt = "R8";
                default: zt = "R9";
            endcase
            ct = (cur.op == 3'b000) ? "R1" : (cur.op == 3'b001) ? "R2" : (cur.op == 3'b010) ? "R3" : "R11";
            vt = (cur.op == 3'b001 || cur.op == 3'b010) ? "R4" : "R11";
            ft = (cur.op == 3'b111) ? "R9" : "R10";
            check(z == cur.z, zt, "result", z, cur.z);
            check(cout == cur.c, ct, "carry", W'(cout), W'(cur.c));
            check(ov == cur.v, vt, "overflow", W'(ov), W'(cur.v));
            check(zero == cur.zf, ft, "zero", W'(zero), W'(cur.zf));
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] corners [0:7];
        corners[0] = 8'h00; corners[1] = 8'hFF; corners[2] = 8'h7F; corners[3] = 8'h80;
        corners[4] = 8'h01; corners[5] = 8'h55; corners[6] = 8'hAA; corners[7] = 8'h0F;

        // Reset-state check: zero inputs with op 000 give a zero result, and R1/R10 flags.
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur = model(3'b000, 8'h00, 8'h00);
        check(z == 8'h00, "R1", "reset result", z, 8'h00);
        check(cout == 1'b0, "R1", "reset carry", W'(cout), 8'h00);
        check(zero == 1'b1, "R10", "reset zero", W'(zero), 8'h01);
        rst_n = 1'b1;

        // Directed corners for every op code: sign boundary, all ones, zero divisor.
        for (int o = 0; o < 8; o++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    drive(3'(o), corners[i], corners[j]);

        // Specific cases: R4 add overflow, R3 borrow, R6 zero divisor, R9 equality.
        drive(3'b001, 8'h7F, 8'h01);
        drive(3'b010, 8'h80, 8'h01);
        drive(3'b010, 8'h03, 8'h05);
        drive(3'b011, 8'hC8, 8'h00);
        drive(3'b011, 8'd200, 8'd7);
        drive(3'b111, 8'h3C, 8'h3C);
        drive(3'b110, 8'hA5, 8'h5A);

        // Pseudo-random sweep across all op codes.
        for (int n = 0; n < 4000; n++) begin
            logic [W-1:0] a, b;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = lfsr[7:0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b = lfsr[15:8] ^ lfsr[7:0];
            drive(3'(n % 8), a, b);
        end

        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule